// File: doc/BRIEF.md
# Asynchronous Serial Byte Receiver

This block receives bytes from a single asynchronous serial line. Each frame has one start bit, eight data bits, no parity and one stop bit. It does not oversample. It uses one down-counter that is loaded with a bit-period count supplied at a port. A falling edge on the idle-high line is taken as the start of a frame. The counter is then loaded with one and a half bit periods, so the first data bit is sampled near its centre. Each later bit is sampled one bit period after the one before it.

A correct stop bit delivers the byte on the data output with a single-cycle valid strobe. A low stop bit parks the receiver in an error state. That state holds, and all further line activity is ignored, until the error-clear input is raised. The stop bit always returns the line to its idle level, so the next start edge is always visible, even when frames follow each other with no gap.

Top module: `uart_frame_rx`

## Requirements
- R1: After reset, `valid_o` is 0, `err_o` is 0 and `data_o` is 0x00.
- R2: The idle line is 1 and the start bit is 0. The eight data bits arrive least significant bit first, and a frame with a stop bit of 1 delivers the byte on `data_o`.
- R3: `valid_o` is high for exactly one clock for each good frame, and never at any other time.
- R4: With P = `bit_period_i` (P >= 4), the first data bit is sampled 1.5P cycles (rounded down) after the start edge is detected, and each later bit P cycles after the one before. `valid_o` rises 3 + floor(3P/2) + 8P clock edges after the line falls.
- R5: Frames sent back to back, each start bit following the previous stop bit with no idle gap, are all received correctly.
- R6: A frame whose stop bit is 0 raises `err_o` and produces no `valid_o` pulse.
- R7: While `err_o` is high it stays high, and frames on the line produce no `valid_o` and do not change `data_o`, until `err_clr_i` is sampled high.
- R8: `err_clr_i` sampled high in the error state clears `err_o` at the next clock, and the next frame is received normally.
- R9: `data_o` changes only together with a `valid_o` pulse. It keeps the last good byte through idle time and through bad frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, idle high, asynchronous to the clock |
| bit_period_i | input | PERIOD_W (16) | Clock cycles per bit, at least 4, held stable during a frame |
| err_clr_i | input | 1 | Leaves the error state |
| data_o | output | 8 | Last byte received with a correct stop bit |
| valid_o | output | 1 | One-clock strobe when a byte is delivered |
| err_o | output | 1 | High while the receiver is parked after a framing error |

## Verification
All 256 byte values are sent back to back at an even bit period. This separates a correct least-significant-bit-first shift from a reversed or misaligned one, and shows that a zero-gap stop-to-start transition is found every time. Shorter streams at odd and larger periods check the 1.5-period rounding and the exact delivery latency for each frame. A bad-stop frame, followed by good frames sent while the receiver is parked and then a clear, separates sticky error behaviour from a receiver that recovers by itself or leaks bytes while in error.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int unsigned FRAME_DATA_BITS = 8;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_DATA = 2'd1,
    ST_STOP = 2'd2,
    ST_ERR  = 2'd3
  } rx_state_e;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic rx_s_o,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b1;
    else         sync_q[0] <= rx_i;
  end

  for (genvar gi = 1; gi < STAGES; gi++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[gi] <= 1'b1;
      else         sync_q[gi] <= sync_q[gi-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign rx_s_o = sync_q[STAGES-1];
  assign fall_o = prev_q & ~sync_q[STAGES-1];

endmodule

// File: rtl/uart_rx_timer.sv
module uart_rx_timer #(
  parameter int unsigned CNT_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             tick_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (load_i)                   cnt_q <= load_val_i;
    else if (run_i && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign tick_o = run_i && (cnt_q == '0);

  // R4
  tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && load_i && load_val_i != '0) |=> !tick_o);

endmodule

// File: rtl/uart_rx_shift.sv
module uart_rx_shift #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] data_o,
  output logic              last_o
);

  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      cnt_q  <= '0;
    end else if (shift_i) begin
      // lsb first: new bit enters at msb and moves down
      data_q <= {bit_i, data_q[DATA_W-1:1]};
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign data_o = data_q;
  assign last_o = (cnt_q == CNT_W'(DATA_W-1));

  // R2
  clr_shift_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clr_i && shift_i));

endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
  import uart_rx_pkg::*;
#(
  parameter int unsigned PERIOD_W    = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned DATA_W     = FRAME_DATA_BITS,
  localparam int unsigned TMR_W      = PERIOD_W + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rx_i,
  input  logic [PERIOD_W-1:0] bit_period_i,
  input  logic                err_clr_i,
  output logic [DATA_W-1:0]   data_o,
  output logic                valid_o,
  output logic                err_o
);

  rx_state_e         state_q, state_d;
  logic              rx_s, rx_fall;
  logic              tmr_load, tmr_tick, tmr_run;
  logic [TMR_W-1:0]  tmr_val, per_ld, half_ld;
  logic              shift_en, shift_clr, shift_last;
  logic [DATA_W-1:0] shift_data;
  logic              deliver;
  logic [DATA_W-1:0] data_q;
  logic              valid_q;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rx_i   (rx_i),
    .rx_s_o (rx_s),
    .fall_o (rx_fall)
  );

  // counts of P and 1.5P, minus one for the zero-terminal down-counter
  assign per_ld  = {1'b0, bit_period_i} - 1'b1;
  assign half_ld = {1'b0, bit_period_i} + {2'b00, bit_period_i[PERIOD_W-1:1]} - 1'b1;
  assign tmr_run = (state_q == ST_DATA) || (state_q == ST_STOP);

  uart_rx_timer #(.CNT_W(TMR_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .run_i      (tmr_run),
    .tick_o     (tmr_tick)
  );

  uart_rx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (shift_clr),
    .shift_i (shift_en),
    .bit_i   (rx_s),
    .data_o  (shift_data),
    .last_o  (shift_last)
  );

  always_comb begin
    state_d   = state_q;
    tmr_load  = 1'b0;
    tmr_val   = per_ld;
    shift_en  = 1'b0;
    shift_clr = 1'b0;
    deliver   = 1'b0;
    unique case (state_q)
      ST_WAIT: if (rx_fall) begin
        tmr_load  = 1'b1;
        tmr_val   = half_ld;
        shift_clr = 1'b1;
        state_d   = ST_DATA;
      end
      ST_DATA: if (tmr_tick) begin
        shift_en = 1'b1;
        tmr_load = 1'b1;
        if (shift_last) state_d = ST_STOP;
      end
      ST_STOP: if (tmr_tick) begin
        if (rx_s) begin
          deliver = 1'b1;
          state_d = ST_WAIT;
        end else begin
          state_d = ST_ERR;
        end
      end
      ST_ERR: if (err_clr_i) state_d = ST_WAIT;
      default: state_d = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      valid_q <= deliver;
      if (deliver) data_q <= shift_data;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign err_o   = (state_q == ST_ERR);

  // R3
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R6
  valid_err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && err_o));

  // R7
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !err_clr_i) |=> (err_o && !valid_o));

  // R8
  err_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && err_clr_i) |=> !err_o);

  // R9
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_o) |-> valid_o);

endmodule

// File: tb/sim_uart_frame_rx.sv
module sim_uart_frame_rx;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx = 1'b1;
  logic [15:0] per = 16'd8;
  logic        clr = 1'b0;
  logic [7:0]  data;
  logic        valid, err;

  int n_chk = 0, n_err = 0;
  int cyc = 0;
  int wr = 0, rd = 0;
  logic [7:0] exp_data [0:1023];
  int         exp_t    [0:1023];
  logic       valid_prev = 1'b0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  uart_frame_rx u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .bit_period_i(per),
    .err_clr_i(clr), .data_o(data), .valid_o(valid), .err_o(err)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // receive monitor: byte value R2/R5, latency R4, single pulse R3
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (valid) begin
        if (rd >= wr) check(1'b0, "R3 unexpected valid", data, -1);
        else begin
          check(data == exp_data[rd], "R2 byte", data, exp_data[rd]);
          check(cyc - exp_t[rd] == 3 + int'(per) + int'(per) / 2 + 8 * int'(per),
                "R4 latency", cyc - exp_t[rd], 3 + int'(per) + int'(per) / 2 + 8 * int'(per));
          rd++;
        end
        if (valid_prev) check(1'b0, "R3 pulse width", 2, 1);
      end
      valid_prev <= valid;
    end
  end

  // called at a negedge, returns at a negedge
  task automatic send(input logic [7:0] b, input logic stop, input bit expect_rx);
    if (expect_rx) begin
      exp_data[wr] = b;
      exp_t[wr] = cyc;
      wr++;
    end
    rx = 1'b0;
    repeat (int'(per)) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      repeat (int'(per)) @(negedge clk);
    end
    rx = stop;
    repeat (int'(per)) @(negedge clk);
    rx = 1'b1;
  endtask

  task automatic sweep(input int p, input int cnt);
    per = 16'(p);
    repeat (2 * p) @(negedge clk);
    for (int i = 0; i < cnt; i++) send(8'((i * 37 + p) & 255), 1'b1, 1'b1);
    repeat (3 * p) @(negedge clk);
    check(rd == wr, "R5 all frames received", rd, wr);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(valid == 1'b0, "R1 valid", valid, 0);
    check(err == 1'b0, "R1 err", err, 0);
    check(data == 8'h00, "R1 data", data, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // exhaustive byte sweep, back to back
    per = 16'd8;
    for (int i = 0; i < 256; i++) send(8'(i), 1'b1, 1'b1);
    repeat (24) @(negedge clk);
    check(rd == wr, "R5 exhaustive stream", rd, wr);

    sweep(4, 40);
    sweep(5, 40);
    sweep(13, 40);

    // framing error path
    per = 16'd8;
    repeat (16) @(negedge clk);
    send(8'h5A, 1'b1, 1'b1);
    send(8'hC3, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    check(err == 1'b1, "R6 err set", err, 1);
    check(data == 8'h5A, "R9 data kept after bad frame", data, 8'h5A);
    check(rd == wr, "R6 no byte from bad frame", rd, wr);
    send(8'h11, 1'b1, 1'b0);
    send(8'hEE, 1'b1, 1'b0);
    repeat (20) @(negedge clk);
    check(err == 1'b1, "R7 err sticky", err, 1);
    check(data == 8'h5A, "R7 data unchanged in error", data, 8'h5A);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    check(err == 1'b0, "R8 err cleared", err, 0);
    repeat (4) @(negedge clk);
    send(8'h81, 1'b1, 1'b1);
    repeat (20) @(negedge clk);
    check(rd == wr, "R8 frame after clear", rd, wr);
    check(data == 8'h81, "R8 data after clear", data, 8'h81);
    repeat (50) @(negedge clk);
    check(data == 8'h81, "R9 data held idle", data, 8'h81);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule